// File: doc/BRIEF.md
# Two-Sided Mailbox with Mirrored Flags

This block connects two processors, called side A and side B, that share one clock. Each side reaches its own bank of ten 32-bit words through a small synchronous register port. That port has a word index, a write strobe, write data, a read strobe and combinational read data. A word written into one of a side's four outgoing slots appears in the matching incoming slot of the other side. Per-channel empty and full bits let each end see whether the other end has collected the word.

Beyond the data slots, each side owns a control word. It holds three general flags, which the block copies into the peer's status word after a fixed two-cycle delay. It also holds four general interrupt requests aimed at the peer, which stay raised until the peer acknowledges them. Finally it holds enable masks for the empty, full and general-request interrupt sources. Each side has one level interrupt output built from those masks. A status bit shows when the peer side is being held in reset. Three reset inputs are provided: a global one and one per side, all synchronous and active high.

Top module: `dual_mailbox`

## Requirements
- R1: Word index map per side: 0 to 3 are outgoing slots (read back what was last written), 4 to 7 are incoming slots (read only; writes have no effect), 8 is status, 9 is control; other indices read zero.
- R2: A write to outgoing slot n clears status bit 20+n (empty) on the writer and sets status bit 24+n (full) on the peer from the next cycle; the peer's incoming slot n then returns the written word.
- R3: A read of incoming slot n clears that side's full bit 24+n and sets the writer's empty bit 20+n from the next cycle; a write to the same channel in the same cycle wins.
- R4: After reset, status reads 0x00F00000 on both sides, control reads zero and both interrupt outputs are low.
- R5: Control bits 2:0 read back as written and appear in the peer's status bits 2:0 exactly two cycles after the write.
- R6: Status bit 8 on the writing side is 1 for every cycle in which a flag copy it started is still in flight, at least two cycles per write.
- R7: A control write made while a flag copy is in flight is held and copied immediately after the current one; a later held write replaces an earlier held one.
- R8: Control bits 19:16 are set-only request bits (writing 0 leaves them); the peer's status bits 31:28 show them.
- R9: Writing 1 to status bit 28+n clears the peer's request bit n (write-one-to-clear); all other status bits ignore writes. A new request in the same cycle wins.
- R10: Each interrupt output is the OR over channels of (empty and control bit 20+n), (full and control bit 24+n) and (pending request and control bit 28+n).
- R11: Status bit 7 reads 1 while the peer's reset input is high; a reset of either side empties both directions' channels and clears both mirrored flag copies.
- R12: Status bit 4 reads 1 when any full bit or any pending request bit of that side is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Global synchronous reset, active high |
| rst_a | input | 1 | Side A reset, active high |
| rst_b | input | 1 | Side B reset, active high |
| a_addr | input | 4 | Side A word index |
| a_we | input | 1 | Side A write strobe |
| a_wdata | input | 32 | Side A write data |
| a_re | input | 1 | Side A read strobe (triggers read side effects) |
| a_rdata | output | 32 | Side A read data for a_addr |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | 4 | Side B word index |
| b_we | input | 1 | Side B write strobe |
| b_wdata | input | 32 | Side B write data |
| b_re | input | 1 | Side B read strobe |
| b_rdata | output | 32 | Side B read data for b_addr |
| b_irq | output | 1 | Side B interrupt |

## Verification
The hardest state to reach is a held flag write. A second control write has to land while the first copy is still in flight, and the held value must move into the pipe at the very edge where the first copy lands in the peer. The stimulus writes side B's control word on two consecutive cycles. It then reads the peer status and the writer status on alternate cycles, so that each intermediate flag value and the unbroken busy bit are seen at the cycle where they are due. Peer-reset visibility needs a reset input held during a read, so the bench raises one side's reset between clock edges and samples the other side's status before the edge clears the channels.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int NCH   = 4;
    localparam int DW    = 32;
    localparam int IDX_W = 4;
    localparam int FLG_W = 3;
    localparam int FLAG_LAT = 2;

    localparam logic [IDX_W-1:0] IDX_TX0  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_RX0  = 4'd4;
    localparam logic [IDX_W-1:0] IDX_STAT = 4'd8;
    localparam logic [IDX_W-1:0] IDX_CTRL = 4'd9;

    typedef struct packed {
        logic [NCH-1:0]   gie;
        logic [NCH-1:0]   rie;
        logic [NCH-1:0]   tie;
        logic [NCH-1:0]   gir;
        logic [FLG_W-1:0] flags;
    } ctrl_t;

    typedef struct packed {
        logic [NCH-1:0]   gip;
        logic [NCH-1:0]   full;
        logic [NCH-1:0]   empty;
        logic             busy;
        logic             peer_rst;
        logic             event_pend;
        logic [FLG_W-1:0] flags;
    } stat_t;

    function automatic logic [DW-1:0] pack_ctrl(input ctrl_t c);
        return {c.gie, c.rie, c.tie, c.gir, 13'd0, c.flags};
    endfunction

    function automatic logic [DW-1:0] pack_stat(input stat_t s);
        return {s.gip, s.full, s.empty, 11'd0, s.busy, s.peer_rst,
                2'd0, s.event_pend, 1'b0, s.flags};
    endfunction

endpackage

// File: rtl/mbox_chan_bank.sv
module mbox_chan_bank
    import mbox_pkg::*;
#(
    parameter int N_CH = NCH,
    parameter int D_W  = DW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_CH-1:0]           wr,
    input  logic [D_W-1:0]            wdata,
    input  logic [N_CH-1:0]           rd,
    output logic [N_CH-1:0][D_W-1:0]  data,
    output logic [N_CH-1:0]           full
);

    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                data[n] <= '0;
                full[n] <= 1'b0;
            end else if (wr[n]) begin
                data[n] <= wdata;
                full[n] <= 1'b1;
            end else if (rd[n]) begin
                full[n] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mbox_flag_pipe.sv
module mbox_flag_pipe
    import mbox_pkg::*;
#(
    parameter int F_W = FLG_W,
    parameter int LAT = FLAG_LAT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic [F_W-1:0] wval,
    output logic           busy,
    output logic [F_W-1:0] mirror
);

    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0]  cnt;
    logic [F_W-1:0] cur;
    logic [F_W-1:0] held;
    logic           held_v;
    logic           done;

    assign done = (cnt == CW'(1));
    assign busy = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            cur    <= '0;
            held   <= '0;
            held_v <= 1'b0;
            mirror <= '0;
        end else begin
            if (busy) cnt <= cnt - CW'(1);
            if (done) mirror <= cur;
            if (wr) begin
                if (!busy || (done && !held_v)) begin
                    cur <= wval;
                    cnt <= CW'(LAT);
                end else if (done) begin
                    cur    <= held;
                    cnt    <= CW'(LAT);
                    held   <= wval;
                    held_v <= 1'b1;
                end else begin
                    held   <= wval;
                    held_v <= 1'b1;
                end
            end else if (done && held_v) begin
                cur    <= held;
                cnt    <= CW'(LAT);
                held_v <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mbox_side.sv
module mbox_side
    import mbox_pkg::*;
#(
    parameter int N_CH = NCH,
    parameter int D_W  = DW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IDX_W-1:0]          addr,
    input  logic                      we,
    input  logic [D_W-1:0]            wdata,
    input  logic                      re,
    output logic [D_W-1:0]            rdata,
    output logic                      irq,
    input  logic [N_CH-1:0][D_W-1:0]  tx_data,
    input  logic [N_CH-1:0]           tx_full,
    input  logic [N_CH-1:0][D_W-1:0]  rx_data,
    input  logic [N_CH-1:0]           rx_full,
    input  logic [FLG_W-1:0]          flags_in,
    input  logic                      fup,
    input  logic                      peer_rst,
    input  logic [N_CH-1:0]           gip_in,
    input  logic [N_CH-1:0]           gir_clr,
    output logic [N_CH-1:0]           tx_wr,
    output logic [N_CH-1:0]           rx_rd,
    output logic                      flag_wr,
    output logic [N_CH-1:0]           gip_clr,
    output ctrl_t                     ctrl
);

    logic  wr_ctrl;
    logic  wr_stat;
    stat_t stat;

    assign wr_ctrl = we && (addr == IDX_CTRL);
    assign wr_stat = we && (addr == IDX_STAT);
    assign flag_wr = wr_ctrl;
    assign gip_clr = wr_stat ? wdata[31:28] : '0;

    for (genvar n = 0; n < N_CH; n++) begin : g_dec
        assign tx_wr[n] = we && (addr == IDX_TX0 + IDX_W'(n));
        assign rx_rd[n] = re && (addr == IDX_RX0 + IDX_W'(n));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            ctrl.gir <= (ctrl.gir & ~gir_clr) | (wr_ctrl ? wdata[19:16] : '0);
            if (wr_ctrl) begin
                ctrl.flags <= wdata[2:0];
                ctrl.tie   <= wdata[23:20];
                ctrl.rie   <= wdata[27:24];
                ctrl.gie   <= wdata[31:28];
            end
        end
    end

    always_comb begin
        stat            = '0;
        stat.gip        = gip_in;
        stat.full       = rx_full;
        stat.empty      = ~tx_full;
        stat.busy       = fup;
        stat.peer_rst   = peer_rst;
        stat.event_pend = (|rx_full) || (|gip_in);
        stat.flags      = flags_in;
    end

    always_comb begin
        rdata = '0;
        if (addr < IDX_RX0) begin
            rdata = tx_data[addr[1:0]];
        end else if (addr < IDX_STAT) begin
            rdata = rx_data[addr[1:0]];
        end else if (addr == IDX_STAT) begin
            rdata = pack_stat(stat);
        end else if (addr == IDX_CTRL) begin
            rdata = pack_ctrl(ctrl);
        end
    end

    assign irq = (|(~tx_full & ctrl.tie)) || (|(rx_full & ctrl.rie))
              || (|(gip_in & ctrl.gie));

endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_a,
    input  logic              rst_b,
    input  logic [IDX_W-1:0]  a_addr,
    input  logic              a_we,
    input  logic [DW-1:0]     a_wdata,
    input  logic              a_re,
    output logic [DW-1:0]     a_rdata,
    output logic              a_irq,
    input  logic [IDX_W-1:0]  b_addr,
    input  logic              b_we,
    input  logic [DW-1:0]     b_wdata,
    input  logic              b_re,
    output logic [DW-1:0]     b_rdata,
    output logic              b_irq
);

    logic rst_any, rst_side_a, rst_side_b;
    assign rst_any    = rst || rst_a || rst_b;
    assign rst_side_a = rst || rst_a;
    assign rst_side_b = rst || rst_b;

    logic [NCH-1:0][DW-1:0] a2b_data, b2a_data;
    logic [NCH-1:0]         a2b_full, b2a_full;
    logic [NCH-1:0]         a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
    logic [NCH-1:0]         a_gip_clr, b_gip_clr;
    logic                   a_flag_wr, b_flag_wr;
    logic                   a_fup, b_fup;
    logic [FLG_W-1:0]       a_flags, b_flags;
    ctrl_t                  a_ctrl, b_ctrl;

    mbox_chan_bank #(.N_CH(NCH), .D_W(DW)) u_a2b (
        .clk(clk), .rst(rst_any), .wr(a_tx_wr), .wdata(a_wdata),
        .rd(b_rx_rd), .data(a2b_data), .full(a2b_full)
    );

    mbox_chan_bank #(.N_CH(NCH), .D_W(DW)) u_b2a (
        .clk(clk), .rst(rst_any), .wr(b_tx_wr), .wdata(b_wdata),
        .rd(a_rx_rd), .data(b2a_data), .full(b2a_full)
    );

    mbox_flag_pipe #(.F_W(FLG_W), .LAT(FLAG_LAT)) u_flag_a2b (
        .clk(clk), .rst(rst_any), .wr(a_flag_wr), .wval(a_wdata[FLG_W-1:0]),
        .busy(a_fup), .mirror(b_flags)
    );

    mbox_flag_pipe #(.F_W(FLG_W), .LAT(FLAG_LAT)) u_flag_b2a (
        .clk(clk), .rst(rst_any), .wr(b_flag_wr), .wval(b_wdata[FLG_W-1:0]),
        .busy(b_fup), .mirror(a_flags)
    );

    mbox_side #(.N_CH(NCH), .D_W(DW)) u_side_a (
        .clk(clk), .rst(rst_side_a),
        .addr(a_addr), .we(a_we), .wdata(a_wdata), .re(a_re),
        .rdata(a_rdata), .irq(a_irq),
        .tx_data(a2b_data), .tx_full(a2b_full),
        .rx_data(b2a_data), .rx_full(b2a_full),
        .flags_in(a_flags), .fup(a_fup), .peer_rst(rst_b),
        .gip_in(b_ctrl.gir), .gir_clr(b_gip_clr),
        .tx_wr(a_tx_wr), .rx_rd(a_rx_rd), .flag_wr(a_flag_wr),
        .gip_clr(a_gip_clr), .ctrl(a_ctrl)
    );

    mbox_side #(.N_CH(NCH), .D_W(DW)) u_side_b (
        .clk(clk), .rst(rst_side_b),
        .addr(b_addr), .we(b_we), .wdata(b_wdata), .re(b_re),
        .rdata(b_rdata), .irq(b_irq),
        .tx_data(b2a_data), .tx_full(b2a_full),
        .rx_data(a2b_data), .rx_full(a2b_full),
        .flags_in(b_flags), .fup(b_fup), .peer_rst(rst_a),
        .gip_in(a_ctrl.gir), .gir_clr(a_gip_clr),
        .tx_wr(b_tx_wr), .rx_rd(b_rx_rd), .flag_wr(b_flag_wr),
        .gip_clr(b_gip_clr), .ctrl(b_ctrl)
    );

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
    import mbox_pkg::*;
(
    input logic             clk,
    input logic             rst_any,
    input logic [IDX_W-1:0] a_addr,
    input logic             a_we,
    input logic             a_req0_set,
    input logic [IDX_W-1:0] b_addr,
    input logic             b_we,
    input logic             b_re,
    input logic             b_ack0,
    input logic [NCH-1:0]   a2b_full,
    input logic             a_fup,
    input logic [FLG_W-1:0] b_flags,
    input ctrl_t            a_ctrl,
    input logic             a_irq
);

    AST_FULL_FROM_WRITE: assert property (@(posedge clk) disable iff (rst_any)
        $rose(a2b_full[0]) |-> $past(a_we && a_addr == IDX_TX0)); // R2

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst_any)
        $past(b_re && b_addr == IDX_RX0 && !(a_we && a_addr == IDX_TX0))
        |-> !a2b_full[0]); // R3

    AST_FUP_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst_any)
        $rose(a_fup) |=> a_fup); // R6

    AST_FLAGS_HOLD_AT_START: assert property (@(posedge clk) disable iff (rst_any)
        $rose(a_fup) |-> $stable(b_flags)); // R5

    AST_ACK_CLEARS_REQ: assert property (@(posedge clk) disable iff (rst_any)
        $past(b_we && b_addr == IDX_STAT && b_ack0 && !(a_we && a_addr == IDX_CTRL && a_req0_set))
        |-> !a_ctrl.gir[0]); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst_any)
        (a_ctrl.tie == '0 && a_ctrl.rie == '0 && a_ctrl.gie == '0) |-> !a_irq); // R10

endmodule

bind dual_mailbox mbox_checker chk_i (
    .clk(clk), .rst_any(rst_any),
    .a_addr(a_addr), .a_we(a_we), .a_req0_set(a_wdata[16]),
    .b_addr(b_addr), .b_we(b_we), .b_re(b_re), .b_ack0(b_wdata[28]),
    .a2b_full(a2b_full), .a_fup(a_fup), .b_flags(b_flags),
    .a_ctrl(a_ctrl), .a_irq(a_irq)
);

// File: tb/dual_mailbox_tb_top.sv
module dual_mailbox_tb_top;

    logic        clk = 1'b0;
    logic        rst, rst_a, rst_b;
    logic [3:0]  a_addr, b_addr;
    logic        a_we, a_re, b_we, b_re;
    logic [31:0] a_wdata, b_wdata;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dual_mailbox dut_i (
        .clk(clk), .rst(rst), .rst_a(rst_a), .rst_b(rst_b),
        .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_re(a_re),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_re(b_re),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    typedef struct packed {
        logic        side;  // 0 = A, 1 = B
        logic        rd;    // 1 = read and compare, 0 = write
        logic [3:0]  addr;
        logic [31:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 4'd0, 32'h1111_1111, 4'd2},
        '{1'b1, 1'b1, 4'd8, 32'h01F0_0010, 4'd2},  // R2 full + R12 event
        '{1'b0, 1'b1, 4'd8, 32'h00E0_0000, 4'd2},
        '{1'b1, 1'b1, 4'd4, 32'h1111_1111, 4'd2},
        '{1'b0, 1'b1, 4'd8, 32'h00F0_0000, 4'd3},  // R3 empty again
        '{1'b1, 1'b1, 4'd8, 32'h00F0_0000, 4'd3},
        '{1'b1, 1'b0, 4'd2, 32'hCAFE_F00D, 4'd2},
        '{1'b0, 1'b1, 4'd8, 32'h04F0_0010, 4'd12},
        '{1'b1, 1'b1, 4'd8, 32'h00B0_0000, 4'd2},
        '{1'b0, 1'b1, 4'd6, 32'hCAFE_F00D, 4'd2},
        '{1'b1, 1'b1, 4'd8, 32'h00F0_0000, 4'd3},
        '{1'b0, 1'b1, 4'd0, 32'h1111_1111, 4'd1},  // R1 slot readback
        '{1'b0, 1'b0, 4'd9, 32'h0000_0005, 4'd5},
        '{1'b0, 1'b1, 4'd8, 32'h00F0_0100, 4'd6},  // R6 busy
        '{1'b1, 1'b1, 4'd8, 32'h00F0_0000, 4'd5},
        '{1'b1, 1'b1, 4'd8, 32'h00F0_0005, 4'd5},  // R5 two-cycle copy
        '{1'b0, 1'b1, 4'd8, 32'h00F0_0000, 4'd6},
        '{1'b0, 1'b1, 4'd9, 32'h0000_0005, 4'd5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        a_we = 1'b0; a_re = 1'b0; b_we = 1'b0; b_re = 1'b0;
    endtask

    // starts and ends on a falling edge; one rising edge in between
    task automatic step(input logic side, input logic rd, input logic [3:0] addr,
                        input logic [31:0] val, input string req);
        if (!side) begin
            a_addr = addr;
            if (rd) a_re = 1'b1; else begin a_we = 1'b1; a_wdata = val; end
        end else begin
            b_addr = addr;
            if (rd) b_re = 1'b1; else begin b_we = 1'b1; b_wdata = val; end
        end
        #1;
        if (rd) chk(req, side ? b_rdata : a_rdata, val);
        @(negedge clk);
        idle_bus();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; rst_a = 1'b0; rst_b = 1'b0;
        a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
        idle_bus();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4 reset state
        a_addr = 4'd8; b_addr = 4'd8; #1;
        chk("R4 a status", a_rdata, 32'h00F0_0000);
        chk("R4 b status", b_rdata, 32'h00F0_0000);
        a_addr = 4'd9; b_addr = 4'd9; #1;
        chk("R4 a control", a_rdata, 32'h0);
        chk("R4 b control", b_rdata, 32'h0);
        chk("R4 irq", {30'd0, a_irq, b_irq}, 32'h0);
        @(negedge clk);

        for (int i = 0; i < NV; i++)
            step(VEC[i].side, VEC[i].rd, VEC[i].addr, VEC[i].val,
                 $sformatf("R%0d row %0d", VEC[i].req, i));

        // R7 held flag write: two back-to-back control writes from B
        step(1'b1, 1'b0, 4'd9, 32'h1, "R7");
        step(1'b1, 1'b0, 4'd9, 32'h2, "R7");
        step(1'b0, 1'b1, 4'd8, 32'h00F0_0000, "R7 before first copy");
        step(1'b0, 1'b1, 4'd8, 32'h00F0_0001, "R7 first copy");
        step(1'b1, 1'b1, 4'd8, 32'h00F0_0105, "R7 R6 busy unbroken");
        step(1'b0, 1'b1, 4'd8, 32'h00F0_0002, "R7 held copy");
        step(1'b1, 1'b1, 4'd8, 32'h00F0_0005, "R6 busy drops");

        // R8 / R9 general request and acknowledge
        step(1'b0, 1'b0, 4'd9, 32'h0001_0005, "R8");
        step(1'b1, 1'b1, 4'd8, 32'h10F0_0015, "R8 R12 pending shown");
        step(1'b1, 1'b0, 4'd9, 32'h1000_0002, "R10");
        #1 chk("R10 b irq general", {31'd0, b_irq}, 32'h1);
        step(1'b0, 1'b0, 4'd9, 32'h0000_0005, "R8");
        step(1'b0, 1'b1, 4'd9, 32'h0001_0005, "R8 set-only");
        step(1'b1, 1'b0, 4'd8, 32'h1000_0000, "R9");
        step(1'b0, 1'b1, 4'd9, 32'h0000_0005, "R9 ack clears request");
        #1 chk("R9 b irq after ack", {31'd0, b_irq}, 32'h0);

        // R10 empty-source interrupt
        step(1'b0, 1'b0, 4'd9, 32'h0020_0005, "R10");
        #1 chk("R10 a irq empty", {31'd0, a_irq}, 32'h1);
        step(1'b0, 1'b0, 4'd1, 32'h0000_0001, "R10");
        #1 chk("R10 a irq masked by full", {31'd0, a_irq}, 32'h0);
        step(1'b1, 1'b1, 4'd5, 32'h0000_0001, "R3");
        #1 chk("R3 R10 a irq after peer read", {31'd0, a_irq}, 32'h1);

        // R1 write to an incoming slot is ignored
        step(1'b0, 1'b0, 4'd5, 32'hDEAD_BEEF, "R1");
        step(1'b0, 1'b1, 4'd5, 32'h0, "R1 incoming slot unchanged");
        step(1'b0, 1'b1, 4'd8, 32'h00F0_0002, "R1 R9 status unchanged");
        step(1'b0, 1'b1, 4'd12, 32'h0, "R1 unmapped index");

        // R11 peer reset visibility and channel clearing
        step(1'b0, 1'b0, 4'd3, 32'h0000_0033, "R11");
        rst_b = 1'b1; a_addr = 4'd8; #1;
        chk("R11 peer reset seen", a_rdata, 32'h0070_0082);
        @(negedge clk);
        rst_b = 1'b0; #1;
        chk("R11 channels and flags cleared", a_rdata, 32'h00F0_0000);
        b_addr = 4'd7; #1;
        chk("R11 b incoming slot empty", b_rdata, 32'h0);
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule